// File: doc/BRIEF.md
# Serial Wiper Register Interface

This block is the serial front end of a four-channel digitally programmable potentiometer. It holds one 8-bit wiper setting per channel. A host talks to it over a clocked serial line. While chip select is high, the block waits for a start bit (a logic 1 on the data input). It then takes a two-bit channel address and eight data bits, one bit on each rising clock edge. The register selected by the address is loaded with the new byte one clock after the last data bit.

The same transfer also reads the channel back. Once the address is complete, the block shifts the selected channel's previous setting out, least significant bit first. It does this while the new byte is still shifting in. The serial output comes as a data bit plus an enable, so that several devices can share one wire. The enable is low whenever chip select is low or a non-volatile programming cycle is running.

While that programming cycle runs, a busy flag from the programming sequencer freezes the interface. Lowering chip select abandons any transfer that is not complete.

Top module: `wiper_serial_if`

## Requirements
- R1: After reset every wiper register holds the reset value 0x80, and `dout_en` and `dout` are low while chip select is low.
- R2: With chip select high and busy low, zeros on the data input before the first 1 are skipped. The first 1 sampled is taken as the start bit.
- R3: The two edges after the start bit sample the channel address, bit 0 first then bit 1. The address selects wiper register 0 to 3 (bits `[8*n +: 8]` of `wiper_o`).
- R4: From the edge that samples address bit 1, `dout` presents the addressed register's previous bit 0. Each later data-bit edge advances it by one bit, so bit k appears after data bit k-1 is sampled.
- R5: The eight data bits arrive bit 0 first. The addressed register is unchanged after the edge that samples bit 7, and holds the new byte after the next rising edge.
- R6: A start bit sampled on the second rising edge after bit 7 begins a new transfer, with chip select held high throughout.
- R7: `dout_en` is high exactly when chip select is high and busy is low. `dout` is 0 whenever `dout_en` is low or no read-back bit is due.
- R8: Edges with busy high do not advance the transfer, and the data input is ignored on them. The transfer resumes where it stopped once busy falls.
- R9: Edges with chip select low are ignored. Chip select low abandons a partial transfer, and a transfer abandoned before bit 7 leaves every register unchanged.
- R10: A completed transfer changes only the addressed register. No register changes at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; bits sampled on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| din | input | 1 | Serial data input |
| busy | input | 1 | High while a non-volatile programming cycle runs |
| dout | output | 1 | Serial read-back bit |
| dout_en | output | 1 | Output enable for `dout` (drives a shared line's tri-state buffer) |
| wiper_o | output | 32 | Four wiper settings, channel n in bits [8n+7:8n] |

## Verification
Each result is due a fixed number of rising edges after a known stimulus. The previous bit 0 appears after the edge that takes address bit 1. Bit k of the old value appears after the edge that takes data bit k-1. The new wiper value appears after the edge following data bit 7, and a new start bit is accepted on the edge after that. The bench drives inputs and samples outputs at the falling edge, one step at a time, and compares against a register model it updates only at the commit edge. This pins every check to the exact edge count in the requirements. Busy and abort cases are checked in the same step-wise way: the outputs and wipers are read between the frozen or abandoned edges and the next transfer.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ADDR   = 2'd1,
      ST_DATA   = 2'd2,
      ST_COMMIT = 2'd3
   } wstate_e;

   function automatic int cnt_bits(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/wiper_seq_ctrl.sv
module wiper_seq_ctrl
   import wiper_pkg::*;
#(
   parameter int ADDR_W = 2,
   parameter int DATA_W = 8
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    cs,
   input  logic    busy,
   input  logic    din,
   output wstate_e st,
   output logic    addr_shift,
   output logic    addr_done,
   output logic    data_shift,
   output logic    commit
);

   localparam int CNT_W = cnt_bits(max_of(ADDR_W, DATA_W));
   localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
   localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

   wstate_e          st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             live;

   assign live = cs && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else if (st_q == ST_COMMIT) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else if (!cs) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else if (!busy) begin
         unique case (st_q)
            ST_IDLE: begin
               if (din) begin
                  st_q  <= ST_ADDR;
                  cnt_q <= '0;
               end
            end
            ST_ADDR: begin
               if (cnt_q == ADDR_LAST) begin
                  st_q  <= ST_DATA;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_DATA: begin
               if (cnt_q == DATA_LAST) begin
                  st_q  <= ST_COMMIT;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: begin
               st_q  <= ST_IDLE;
               cnt_q <= '0;
            end
         endcase
      end
   end

   always_comb begin
      addr_shift = live && (st_q == ST_ADDR);
      addr_done  = addr_shift && (cnt_q == ADDR_LAST);
      data_shift = live && (st_q == ST_DATA);
      commit     = (st_q == ST_COMMIT);
   end

   assign st = st_q;

endmodule

// File: rtl/wiper_shift_path.sv
module wiper_shift_path #(
   parameter int ADDR_W         = 2,
   parameter int DATA_W         = 8,
   parameter bit ADDR_MSB_FIRST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              din,
   input  logic              addr_shift,
   input  logic              addr_done,
   input  logic              data_shift,
   input  logic [DATA_W-1:0] rd_val,
   output logic [ADDR_W-1:0] addr_next,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wr_data,
   output logic              rd_bit
);

   logic [ADDR_W-1:0] addr_r;
   logic [DATA_W-1:0] wr_r;
   logic [DATA_W-1:0] rd_r;

   generate
      if (ADDR_W == 1) begin : g_addr_one
         assign addr_next = din;
      end else if (ADDR_MSB_FIRST) begin : g_addr_msb
         assign addr_next = {addr_r[ADDR_W-2:0], din};
      end else begin : g_addr_lsb
         assign addr_next = {din, addr_r[ADDR_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_r <= '0;
      end else if (addr_shift) begin
         addr_r <= addr_next;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_r <= '0;
      end else if (data_shift) begin
         wr_r <= {din, wr_r[DATA_W-1:1]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_r <= '0;
      end else if (addr_done) begin
         rd_r <= rd_val;
      end else if (data_shift) begin
         rd_r <= {1'b0, rd_r[DATA_W-1:1]};
      end
   end

   assign addr_q  = addr_r;
   assign wr_data = wr_r;
   assign rd_bit  = rd_r[0];

endmodule

// File: rtl/wiper_bank.sv
module wiper_bank #(
   parameter int              NUM_REGS  = 4,
   parameter int              DATA_W    = 8,
   parameter logic [DATA_W-1:0] RESET_VAL = 8'h80,
   localparam int             ADDR_W    = $clog2(NUM_REGS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [ADDR_W-1:0]          waddr,
   input  logic [DATA_W-1:0]          wdata,
   input  logic [ADDR_W-1:0]          raddr,
   output logic [DATA_W-1:0]          rdata,
   output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

   logic [DATA_W-1:0] regs [NUM_REGS];

   generate
      for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               regs[gi] <= RESET_VAL;
            end else if (we && (waddr == ADDR_W'(gi))) begin
               regs[gi] <= wdata;
            end
         end
         assign regs_flat[gi*DATA_W +: DATA_W] = regs[gi];
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (raddr == ADDR_W'(i)) rdata = regs[i];
      end
   end

endmodule

// File: rtl/wiper_serial_if.sv
module wiper_serial_if
   import wiper_pkg::*;
#(
   parameter int                NUM_REGS       = 4,
   parameter int                DATA_W         = 8,
   parameter logic [DATA_W-1:0] RESET_VAL      = 8'h80,
   parameter bit                ADDR_MSB_FIRST = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cs,
   input  logic                       din,
   input  logic                       busy,
   output logic                       dout,
   output logic                       dout_en,
   output logic [NUM_REGS*DATA_W-1:0] wiper_o
);

   localparam int ADDR_W = $clog2(NUM_REGS);

   generate
      if (NUM_REGS < 2) begin : g_bad_regs
         $error("wiper_serial_if: NUM_REGS must be at least 2");
      end
      if ((1 << ADDR_W) != NUM_REGS) begin : g_bad_pow2
         $error("wiper_serial_if: NUM_REGS must be a power of two");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("wiper_serial_if: DATA_W must be at least 2");
      end
   endgenerate

   wstate_e           st;
   logic              addr_shift;
   logic              addr_done;
   logic              data_shift;
   logic              commit;
   logic [ADDR_W-1:0] addr_next;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wr_data;
   logic [DATA_W-1:0] rd_val;
   logic              rd_bit;

   wiper_seq_ctrl #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs         (cs),
      .busy       (busy),
      .din        (din),
      .st         (st),
      .addr_shift (addr_shift),
      .addr_done  (addr_done),
      .data_shift (data_shift),
      .commit     (commit)
   );

   wiper_shift_path #(
      .ADDR_W         (ADDR_W),
      .DATA_W         (DATA_W),
      .ADDR_MSB_FIRST (ADDR_MSB_FIRST)
   ) u_path (
      .clk        (clk),
      .rst_n      (rst_n),
      .din        (din),
      .addr_shift (addr_shift),
      .addr_done  (addr_done),
      .data_shift (data_shift),
      .rd_val     (rd_val),
      .addr_next  (addr_next),
      .addr_q     (addr_q),
      .wr_data    (wr_data),
      .rd_bit     (rd_bit)
   );

   wiper_bank #(
      .NUM_REGS  (NUM_REGS),
      .DATA_W    (DATA_W),
      .RESET_VAL (RESET_VAL)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (commit),
      .waddr     (addr_q),
      .wdata     (wr_data),
      .raddr     (addr_next),
      .rdata     (rd_val),
      .regs_flat (wiper_o)
   );

   assign dout_en = cs && !busy;
   assign dout    = (dout_en && (st == ST_DATA)) ? rd_bit : 1'b0;

endmodule

// File: rtl/wiper_serial_chk.sv
module wiper_serial_chk
   import wiper_pkg::*;
#(
   parameter int NUM_REGS = 4,
   parameter int DATA_W   = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       cs,
   input logic                       busy,
   input logic                       dout,
   input logic                       dout_en,
   input wstate_e                    st,
   input logic                       commit,
   input logic [NUM_REGS*DATA_W-1:0] wiper_o
);

   assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_en |-> (dout == 1'b0));

   assert_abort_on_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs && (st != ST_COMMIT)) |=> (st == ST_IDLE));

   assert_freeze_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && busy && (st != ST_COMMIT)) |=> $stable(st));

   assert_ready_after_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_COMMIT) |=> (st == ST_IDLE));

   assert_wipers_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(wiper_o));

endmodule

bind wiper_serial_if wiper_serial_chk #(
   .NUM_REGS (NUM_REGS),
   .DATA_W   (DATA_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cs      (cs),
   .busy    (busy),
   .dout    (dout),
   .dout_en (dout_en),
   .st      (st),
   .commit  (commit),
   .wiper_o (wiper_o)
);

// File: tb/tb_wiper_serial_if.sv
module tb_wiper_serial_if;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs = 1'b0;
   logic        din = 1'b0;
   logic        busy = 1'b0;
   logic        dout;
   logic        dout_en;
   logic [31:0] wiper_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   logic [7:0] model [4];

   always #(CLK_P/2) clk = ~clk;

   wiper_serial_if dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs      (cs),
      .din     (din),
      .busy    (busy),
      .dout    (dout),
      .dout_en (dout_en),
      .wiper_o (wiper_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic c, input logic d, input logic b);
      cs = c; din = d; busy = b;
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [7:0] wv(input int a);
      return wiper_o[a*8 +: 8];
   endfunction

   task automatic chk_all(input string tag);
      for (int a = 0; a < 4; a++) chk(tag, {24'h0, wv(a)}, {24'h0, model[a]});
   endtask

   // full transfer; busy_at >= 0 inserts three busy edges before data bit busy_at
   task automatic xfer(input int a, input logic [7:0] d, input int lead,
                       input bit keep_cs, input int busy_at);
      logic [7:0] old;
      old = model[a];
      for (int z = 0; z < lead; z++) step(1'b1, 1'b0, 1'b0);       // R2 leading zeros
      step(1'b1, 1'b1, 1'b0);                                      // start
      step(1'b1, a[0], 1'b0);                                      // R3 A0
      step(1'b1, a[1], 1'b0);                                      // R3 A1
      chk("R4 first read-back bit", {31'h0, dout}, {31'h0, old[0]});
      chk("R7 enable during transfer", {31'h0, dout_en}, 32'h1);
      for (int i = 0; i < 8; i++) begin
         if (i == busy_at) begin
            for (int q = 0; q < 3; q++) begin
               step(1'b1, q[0], 1'b1);
               chk("R7 enable off when busy", {31'h0, dout_en}, 32'h0);
               chk("R7 dout low when busy", {31'h0, dout}, 32'h0);
            end
            busy = 1'b0;
            #1;
            chk("R8 read-back resumes", {31'h0, dout}, {31'h0, old[i]});
         end
         step(1'b1, d[i], 1'b0);
         if (i < 7) chk("R4 read-back bit", {31'h0, dout}, {31'h0, old[i+1]});
      end
      chk("R5 unchanged right after D7", {24'h0, wv(a)}, {24'h0, old});
      step(keep_cs, 1'b0, 1'b0);
      model[a] = d;
      chk_all("R5 R10 commit");
      if (!keep_cs) step(1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int a = 0; a < 4; a++) model[a] = 8'h80;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_all("R1 reset value");
      chk("R1 dout_en low", {31'h0, dout_en}, 32'h0);
      chk("R1 dout low", {31'h0, dout}, 32'h0);

      // R9: edges with cs low are ignored
      for (int q = 0; q < 3; q++) step(1'b0, 1'b1, 1'b0);
      chk("R7 enable off when deselected", {31'h0, dout_en}, 32'h0);
      xfer(2, 8'h5A, 0, 1'b0, -1);

      // sweep over addresses and data patterns
      for (int a = 0; a < 4; a++) begin
         for (int k = 0; k < 16; k++) begin
            logic [7:0] d;
            d = 8'((k * 73 + a * 29 + 5) & 255);
            if (k == 0) d = 8'h00;
            if (k == 15) d = 8'hFF;
            xfer(a, d, k % 3, k[0], -1);   // R6 back-to-back when cs kept high
         end
      end

      // R8: busy during idle with din high must not start a transfer
      for (int q = 0; q < 3; q++) step(1'b1, 1'b1, 1'b1);
      step(1'b1, 1'b0, 1'b0);
      xfer(1, 8'hC3, 0, 1'b1, -1);
      // R8: busy in the middle of the data bits
      xfer(3, 8'h96, 1, 1'b0, 4);
      xfer(0, 8'h2D, 0, 1'b1, 0);

      // R9: abort after five data bits
      step(1'b1, 1'b1, 1'b0);
      step(1'b1, 1'b1, 1'b0);
      step(1'b1, 1'b0, 1'b0);          // address 1
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0);
      chk("R7 dout low after abort", {31'h0, dout}, 32'h0);
      step(1'b0, 1'b0, 1'b0);
      chk_all("R9 abort leaves registers");
      xfer(1, 8'h3C, 2, 1'b0, -1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule